// File: doc/BRIEF.md
# Receive PCM Serial Slot Capture

This block pulls one 8-bit companded sample off a serial data line during a receive time slot. The slot is framed by a receive sync input and paced by a bit clock; all capture happens on falling bit-clock edges. Two sync forms are accepted. A one-period sync (short form) puts the first data bit on the edge after the one that saw the sync. A sync lasting two or more periods (long form) puts the first data bit on the edge that first sees the sync high. The form is judged frame by frame from the sync width, so no mode input is needed.

When the last bit of a slot is latched, the word is presented on a parallel output together with a one-period valid strobe. A sync exactly two periods long means the least significant bit carries signalling. The eighth bit is still captured, but a flag is raised beside the word so that the expander downstream can substitute a half-step value. A fresh sync during a slot abandons the partial word. Expansion to linear form and everything analog lie outside this block.

Top module: `pcm_slot_rx`

## Requirements
- R1: While reset is high and after its release, until the first completed slot, the word output is 0, the valid strobe is 0 and the LSB-lost flag is 0.
- R2: Short form: if the sync is sampled high on falling edge N and low on edge N+1, the bits on edges N+1 to N+8 form the word, MSB first. The data bit on edge N has no effect on the word.
- R3: Long form: if the sync is sampled low on one falling edge and high on the next three or more, with edge N the first high one, the bits on edges N to N+7 form the word, MSB first.
- R4: Valid rises at the falling edge that latches the last bit and stays high for exactly one bit-clock period. Word and LSB-lost flag change only at that edge and hold until the next completion.
- R5: A sync sampled high on exactly two consecutive falling edges uses long-form timing, captures all eight bits and sets the LSB-lost flag to 1 with that word. Any other sync width gives a flag of 0.
- R6: A sync sampled low then high while a slot is still incomplete restarts capture from that edge. The partial word is discarded and no valid pulse is produced for it.
- R7: In short form, a sync sampled high on the same edge that latches the final bit still completes the current word and also starts the next slot.
- R8: With the sync held low and no slot in progress, activity on the data line produces no valid pulse and leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; all sampling on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| syncIn | input | 1 | Receive frame sync |
| dataIn | input | 1 | Serial PCM data, MSB first |
| word | output | 8 | Last completed sample |
| wordValid | output | 1 | One-period strobe when a sample completes |
| lsbLost | output | 1 | Set with a word whose LSB was taken by signalling |

## Verification
Every 8-bit value is sent under four sync widths: one period, two periods, three periods and five periods. This separates short timing from long timing by the one-edge offset of the captured bits. It also separates the signalling width from the ordinary long widths by the flag. In short frames the discarded bit on the sync edge is driven as the inverse of the MSB, so any off-by-one in the start rule changes the word. Further sequences abort a slot in each form with a new sync, run two short frames back to back with the sync landing on the final bit edge, and toggle the data line while the sync stays low.

// File: rtl/pcm_slot_rx_pkg.sv
`timescale 1ns/1ps
package pcm_slot_rx_pkg;
  // Strobes from control to datapath, valid for one falling edge
  typedef struct packed {
    logic start;  // begin a slot with the present data bit
    logic shift;  // append the present data bit
    logic load;   // slot complete: publish word
    logic lost;   // completed word had its LSB stolen
  } slotStrb_t;
endpackage

// File: rtl/pcm_slot_rx_ctl.sv
`timescale 1ns/1ps
module pcm_slot_rx_ctl
  import pcm_slot_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      bitClk,
  input  logic      rst,
  input  logic      syncIn,
  output slotStrb_t strb
);
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(W);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);

  logic             syncPrev;
  logic             active;
  logic [CNT_W-1:0] cnt;       // bits shifted since slot start
  logic             longSeen;  // sync still high on second edge
  logic             lostSeen;  // sync low again on third edge
  logic             startEv;
  logic             longNow;
  logic [CNT_W-1:0] nextCnt;
  logic             done;

  always_comb begin
    startEv = syncIn & ~syncPrev;
    longNow = (cnt == ONE) ? syncIn : longSeen;
    nextCnt = cnt + ONE;
    done    = active & ((longNow & (nextCnt == LONG_END)) |
                        (~longNow & (nextCnt == SHORT_END)));
    strb.start = startEv;
    strb.shift = active & ~startEv;
    strb.load  = done;
    strb.lost  = longSeen & lostSeen;
  end

  always_ff @(negedge bitClk) begin
    if (rst) begin
      syncPrev <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      longSeen <= 1'b0;
      lostSeen <= 1'b0;
    end else begin
      syncPrev <= syncIn;
      if (startEv) begin
        active   <= 1'b1;
        cnt      <= ONE;
        longSeen <= 1'b0;
        lostSeen <= 1'b0;
      end else if (done) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= nextCnt;
        if (cnt == ONE) longSeen <= syncIn;
        if (cnt == TWO) lostSeen <= longSeen & ~syncIn;
      end
    end
  end

  // R6: a new sync always reopens the slot at its first bit
  p_restart_r6: assert property (@(negedge bitClk) disable iff (rst)
    startEv |=> (active && cnt == ONE));

  // R4: a running slot never runs past its last bit
  p_cnt_range_r4: assert property (@(negedge bitClk) disable iff (rst)
    active |-> (cnt != '0 && cnt <= LONG_END));
endmodule

// File: rtl/pcm_slot_rx_dp.sv
`timescale 1ns/1ps
module pcm_slot_rx_dp
  import pcm_slot_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         bitClk,
  input  logic         rst,
  input  logic         dataIn,
  input  slotStrb_t    strb,
  output logic [W-1:0] word,
  output logic         wordValid,
  output logic         lsbLost
);
  localparam int HIST_W = W - 1;

  logic [HIST_W-1:0] hist;  // bits received so far in this slot

  always_ff @(negedge bitClk) begin
    if (rst) begin
      hist      <= '0;
      word      <= '0;
      wordValid <= 1'b0;
      lsbLost   <= 1'b0;
    end else begin
      if (strb.start)      hist <= HIST_W'(dataIn);
      else if (strb.shift) hist <= {hist[HIST_W-2:0], dataIn};
      wordValid <= strb.load;
      if (strb.load) begin
        word    <= {hist, dataIn};
        lsbLost <= strb.lost;
      end
    end
  end

  // R4: the strobe lasts one period
  p_valid_single_r4: assert property (@(negedge bitClk) disable iff (rst)
    wordValid |=> !wordValid);

  // R4: outputs hold between completions
  p_word_hold_r4: assert property (@(negedge bitClk) disable iff (rst)
    !strb.load |=> ($stable(word) && $stable(lsbLost)));

  // R5: the flag only appears together with a fresh word
  p_lost_with_valid_r5: assert property (@(negedge bitClk) disable iff (rst)
    $rose(lsbLost) |-> wordValid);
endmodule

// File: rtl/pcm_slot_rx.sv
`timescale 1ns/1ps
module pcm_slot_rx
  import pcm_slot_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         bitClk,
  input  logic         rst,
  input  logic         syncIn,
  input  logic         dataIn,
  output logic [W-1:0] word,
  output logic         wordValid,
  output logic         lsbLost
);
  slotStrb_t strb;

  pcm_slot_rx_ctl #(.W(W)) ctl_i (
    .bitClk (bitClk),
    .rst    (rst),
    .syncIn (syncIn),
    .strb   (strb)
  );

  pcm_slot_rx_dp #(.W(W)) dp_i (
    .bitClk    (bitClk),
    .rst       (rst),
    .dataIn    (dataIn),
    .strb      (strb),
    .word      (word),
    .wordValid (wordValid),
    .lsbLost   (lsbLost)
  );
endmodule

// File: tb/pcm_slot_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_slot_rx_tb_top;
  logic       bitClk = 1'b0;
  logic       rst = 1'b1;
  logic       syncIn = 1'b0;
  logic       dataIn = 1'b0;
  logic [7:0] word;
  logic       wordValid;
  logic       lsbLost;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 bitClk = ~bitClk;

  pcm_slot_rx #(.W(8)) dut_i (
    .bitClk(bitClk), .rst(rst), .syncIn(syncIn), .dataIn(dataIn),
    .word(word), .wordValid(wordValid), .lsbLost(lsbLost)
  );

  task automatic checkVal(input bit ok, input string req,
                          input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Present inputs for the next falling edge; outputs then reflect the previous one
  task automatic drive(input logic f, input logic d);
    @(posedge bitClk);
    #2;
    syncIn = f;
    dataIn = d;
  endtask

  task automatic sendFrame(input logic [7:0] w, input int syncLen, input string midTag);
    int lastE;
    string tag;
    lastE = (syncLen == 1) ? 8 : 7;
    tag = (syncLen == 1) ? "R2" : ((syncLen == 2) ? "R5" : "R3");
    for (int e = 0; e <= lastE; e++) begin
      logic d;
      if (syncLen == 1) d = (e == 0) ? ~w[7] : w[8-e];
      else              d = w[7-e];
      drive(e < syncLen, d);
      checkVal(wordValid == 1'b0, midTag, wordValid, 0);
    end
    drive(1'b0, w[0]);
    checkVal(wordValid == 1'b1, tag, wordValid, 1);
    checkVal(word == w, tag, word, w);
    checkVal(lsbLost == (syncLen == 2), tag, lsbLost, (syncLen == 2));
    drive(1'b0, ~w[0]);
    checkVal(wordValid == 1'b0, "R4", wordValid, 0);
    checkVal(word == w, "R4", word, w);
  endtask

  initial begin
    logic [7:0] held;
    logic [7:0] a;
    logic [7:0] b;
    repeat (3) @(posedge bitClk);
    #2;
    // R1 during reset
    checkVal(word == 8'h00, "R1", word, 0);
    checkVal(wordValid == 1'b0, "R1", wordValid, 0);
    checkVal(lsbLost == 1'b0, "R1", lsbLost, 0);
    rst = 1'b0;
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    checkVal(word == 8'h00 && !wordValid && !lsbLost, "R1", {word, wordValid, lsbLost}, 0);

    // R2, R3, R5 sweep: every value under four sync widths
    for (int v = 0; v < 256; v++) begin
      sendFrame(8'(v), 1, "R4");
      sendFrame(8'(v), 2, "R4");
      sendFrame(8'(v), 3, "R4");
      sendFrame(8'(v), 5, "R4");
    end

    // R6 long-form abort: five edges in, then a new long sync
    drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    drive(1'b0, 1'b0); drive(1'b0, 1'b1);
    sendFrame(8'h96, 3, "R6");
    // R6 short-form abort: three bits in, then a new short sync
    drive(1'b1, 1'b0); drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b0, 1'b1);
    sendFrame(8'h4D, 1, "R6");
    // R6 long abort resolved into a signalling frame
    drive(1'b1, 1'b0); drive(1'b1, 1'b1); drive(1'b1, 1'b1); drive(1'b0, 1'b0);
    sendFrame(8'hE1, 2, "R6");

    // R7 back-to-back short frames
    a = 8'hC5;
    b = 8'h3A;
    drive(1'b1, 1'b0);
    for (int e = 1; e <= 7; e++) drive(1'b0, a[8-e]);
    drive(1'b1, a[0]);
    for (int e = 9; e <= 16; e++) begin
      drive(1'b0, b[16-e]);
      if (e == 9) begin
        checkVal(wordValid == 1'b1, "R7", wordValid, 1);
        checkVal(word == a, "R7", word, a);
      end else begin
        checkVal(wordValid == 1'b0, "R7", wordValid, 0);
      end
    end
    drive(1'b0, 1'b0);
    checkVal(wordValid == 1'b1, "R7", wordValid, 1);
    checkVal(word == b, "R7", word, b);
    checkVal(lsbLost == 1'b0, "R7", lsbLost, 0);
    drive(1'b0, 1'b1);

    // R8 idle data activity
    held = word;
    for (int i = 0; i < 24; i++) begin
      drive(1'b0, i[0] ^ i[2]);
      checkVal(wordValid == 1'b0, "R8", wordValid, 0);
      checkVal(word == held, "R8", word, held);
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule